// File: doc/BRIEF.md
# Bidirectional I/O Port with Pull-ups

This block is a general-purpose I/O port that is WIDTH bits wide (eight by default). It is programmed through a small register bus with an address, a write strobe, write data and combinational read data. The bus reaches three locations. The direction register decides, one bit at a time, whether each pin drives the pad or listens to it. The drive register does two jobs, depending on that direction bit. On an output bit it sets the level that goes out. On an input bit it turns on the pad's weak pull-up. The third location is a read-only view of the pad levels. These levels pass through a two-stage synchronizer first.

On the pad side, each bit has an output value, an output enable, a pull-up enable and a pad input. A neighbouring peripheral can take over the output value of any pin through a per-bit select and value. The output enable still comes from the direction register. So a peripheral only reaches the pad if its pin is set as an output.

Top module: `pio_bank`

## Requirements
- R1: While reset is asserted and after it is released, the direction and drive registers read 0, and pad_oe, pad_pu and pad_out are all 0. Every pin therefore starts as an input with no pull-up.
- R2: A write to address 1 stores the data in the direction register at the next rising clock edge. A 1 in a bit makes that pin an output and raises its pad_oe; a 0 makes it an input. Reading address 1 returns the stored value.
- R3: A write to address 2 stores the drive register. On a pin with no peripheral override, pad_out equals that pin's drive bit.
- R4: pad_pu of a bit is 1 exactly when its direction bit is 0 and its drive bit is 1. pad_pu and pad_oe are never both 1 on the same bit.
- R5: Reading address 0 returns the pad_in levels of all bits, whatever their direction. A change on pad_in appears there after the second rising clock edge that follows it, and not after the first.
- R6: Writes to address 0 are ignored. The direction and drive registers and the pad outputs keep their values.
- R7: When alt_sel of a bit is 1, pad_out of that bit equals alt_val. pad_oe of that bit still follows the direction bit.
- R8: Address 3 reads as 0, and writes to it change no register.
- R9: With bus_we low, no register changes, whatever the address and write data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 2 | Register address: 0 pin levels, 1 direction, 2 drive, 3 unused |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | WIDTH | Write data |
| bus_rdata | output | WIDTH | Read data for bus_addr, combinational |
| pad_in | input | WIDTH | Levels seen at the pads |
| alt_sel | input | WIDTH | Per-bit peripheral override select |
| alt_val | input | WIDTH | Per-bit peripheral output value |
| pad_out | output | WIDTH | Output value to each pad |
| pad_oe | output | WIDTH | Output buffer enable per pad |
| pad_pu | output | WIDTH | Pull-up enable per pad |

## Verification
The pad-control function is tried with several direction and drive pairs: all outputs, all inputs, and mixed nibbles. Only the mixed pairs show whether the drive bit reaches pad_out or pad_pu, so they separate its two jobs. The synchronizer is sampled after one edge and after two edges, with the pins set first as inputs and then as outputs. This separates a correct two-stage lag from a shorter or longer lag, and from a path gated by direction. For the override, some bits are overridden with values that differ from their drive bits, on pins set as inputs and as outputs. This shows that the value is replaced while the enable is not.

// File: rtl/pio_pkg.sv
package pio_pkg;

  localparam int ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    ADR_LEVEL = 2'd0,
    ADR_DIR   = 2'd1,
    ADR_DRIVE = 2'd2,
    ADR_SPARE = 2'd3
  } pio_addr_e;

  // Pull-up is wanted on listening bits whose drive bit is set.
  function automatic logic pull_bit(input logic dir_b, input logic drv_b);
    return (~dir_b) & drv_b;
  endfunction

  // Output value: the peripheral wins when it selects the bit.
  function automatic logic out_bit(input logic drv_b, input logic sel_b, input logic val_b);
    return sel_b ? val_b : drv_b;
  endfunction

endpackage

// File: rtl/pio_regs.sv
module pio_regs
  import pio_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              we,
  input  logic [WIDTH-1:0]  wdata,
  input  logic [WIDTH-1:0]  level,
  output logic [WIDTH-1:0]  rdata,
  output logic [WIDTH-1:0]  dir_q,
  output logic [WIDTH-1:0]  drv_q
);

  pio_addr_e sel;
  assign sel = pio_addr_e'(addr);

  // named write events
  logic wr_dir, wr_drv, wr_level_dropped, wr_spare_dropped;
  assign wr_dir           = we && (sel == ADR_DIR);
  assign wr_drv           = we && (sel == ADR_DRIVE);
  assign wr_level_dropped = we && (sel == ADR_LEVEL);
  assign wr_spare_dropped = we && (sel == ADR_SPARE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q <= '0;
      drv_q <= '0;
    end else begin
      if (wr_dir) dir_q <= wdata;
      if (wr_drv) drv_q <= wdata;
    end
  end

  always_comb begin
    unique case (sel)
      ADR_LEVEL: rdata = level;
      ADR_DIR:   rdata = dir_q;
      ADR_DRIVE: rdata = drv_q;
      default:   rdata = '0;
    endcase
  end

  assert_dir_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_dir |=> (dir_q == $past(wdata)));

  assert_level_write_dropped_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_level_dropped |=> ($stable(dir_q) && $stable(drv_q)));

  assert_spare_write_dropped_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_spare_dropped |=> ($stable(dir_q) && $stable(drv_q)));

  assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> ($stable(dir_q) && $stable(drv_q)));

endmodule

// File: rtl/pio_sync.sv
module pio_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] raw,
  output logic [WIDTH-1:0] synced
);

  localparam int LAST = STAGES - 1;

  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q[0] <= '0;
    else        stage_q[0] <= raw;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_chain
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[s] <= '0;
      else        stage_q[s] <= stage_q[s-1];
    end
  end

  assign synced = stage_q[LAST];

  // becomes 1 one edge after reset release so $past never reaches into reset
  logic up_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) up_q <= 1'b0;
    else        up_q <= 1'b1;
  end

  assert_first_stage_R5: assert property (@(posedge clk) disable iff (!rst_n)
    up_q |-> (stage_q[0] == $past(raw)));

  assert_chain_shift_R5: assert property (@(posedge clk) disable iff (!rst_n)
    up_q |-> (synced == $past(stage_q[LAST-1])));

endmodule

// File: rtl/pio_pad_ctrl.sv
module pio_pad_ctrl
  import pio_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] dir_q,
  input  logic [WIDTH-1:0] drv_q,
  input  logic [WIDTH-1:0] alt_sel,
  input  logic [WIDTH-1:0] alt_val,
  output logic [WIDTH-1:0] pad_out,
  output logic [WIDTH-1:0] pad_oe,
  output logic [WIDTH-1:0] pad_pu
);

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    assign pad_out[i] = out_bit(drv_q[i], alt_sel[i], alt_val[i]);
    assign pad_oe[i]  = dir_q[i];
    assign pad_pu[i]  = pull_bit(dir_q[i], drv_q[i]);
  end

  assert_pu_oe_exclusive_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_pu & pad_oe) == '0);

endmodule

// File: rtl/pio_bank.sv
module pio_bank
  import pio_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [WIDTH-1:0]  bus_wdata,
  output logic [WIDTH-1:0]  bus_rdata,
  input  logic [WIDTH-1:0]  pad_in,
  input  logic [WIDTH-1:0]  alt_sel,
  input  logic [WIDTH-1:0]  alt_val,
  output logic [WIDTH-1:0]  pad_out,
  output logic [WIDTH-1:0]  pad_oe,
  output logic [WIDTH-1:0]  pad_pu
);

  logic [WIDTH-1:0] level_sync;
  logic [WIDTH-1:0] dir_q;
  logic [WIDTH-1:0] drv_q;

  pio_sync #(.WIDTH(WIDTH), .STAGES(2)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .raw    (pad_in),
    .synced (level_sync)
  );

  pio_regs #(.WIDTH(WIDTH)) u_regs (
    .clk   (clk),
    .rst_n (rst_n),
    .addr  (bus_addr),
    .we    (bus_we),
    .wdata (bus_wdata),
    .level (level_sync),
    .rdata (bus_rdata),
    .dir_q (dir_q),
    .drv_q (drv_q)
  );

  pio_pad_ctrl #(.WIDTH(WIDTH)) u_pad (
    .clk     (clk),
    .rst_n   (rst_n),
    .dir_q   (dir_q),
    .drv_q   (drv_q),
    .alt_sel (alt_sel),
    .alt_val (alt_val),
    .pad_out (pad_out),
    .pad_oe  (pad_oe),
    .pad_pu  (pad_pu)
  );

  // R1: reset leaves every pin listening with pull-up off
  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rst_n |-> (pad_oe == '0 && pad_pu == '0));

endmodule

// File: tb/tb_pio_bank.sv
`timescale 1ns/1ps
module tb_pio_bank;

  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [1:0]   bus_addr = '0;
  logic         bus_we = 1'b0;
  logic [W-1:0] bus_wdata = '0;
  logic [W-1:0] bus_rdata;
  logic [W-1:0] pad_in = '0;
  logic [W-1:0] alt_sel = '0;
  logic [W-1:0] alt_val = '0;
  logic [W-1:0] pad_out, pad_oe, pad_pu;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  pio_bank #(.WIDTH(W)) dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
    .alt_sel(alt_sel), .alt_val(alt_val), .pad_out(pad_out),
    .pad_oe(pad_oe), .pad_pu(pad_pu)
  );

  task automatic chk(input string req, input string what, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%02h expected=%02h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [W-1:0] d);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b1; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [W-1:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic t_reset();
    logic [W-1:0] v;
    chk("R1", "pad_oe in reset", pad_oe, 8'h00);
    chk("R1", "pad_pu in reset", pad_pu, 8'h00);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    rd(2'd1, v); chk("R1", "dir after reset", v, 8'h00);
    rd(2'd2, v); chk("R1", "drive after reset", v, 8'h00);
    chk("R1", "pad_out after reset", pad_out, 8'h00);
    chk("R1", "pad_oe after reset", pad_oe, 8'h00);
  endtask

  task automatic t_dir_and_idle();
    logic [W-1:0] v;
    wr(2'd1, 8'hA5);
    rd(2'd1, v); chk("R2", "dir readback", v, 8'hA5);
    chk("R2", "pad_oe follows dir", pad_oe, 8'hA5);
    bus_addr = 2'd1; bus_wdata = 8'hFF; bus_we = 1'b0;
    @(negedge clk); @(negedge clk);
    rd(2'd1, v); chk("R9", "dir held with we low", v, 8'hA5);
    bus_addr = 2'd2;
    @(negedge clk);
    rd(2'd2, v); chk("R9", "drive held with we low", v, 8'h00);
  endtask

  task automatic t_drive_outputs();
    wr(2'd1, 8'hFF);
    wr(2'd2, 8'h3C);
    chk("R3", "pad_out all outputs", pad_out, 8'h3C);
    chk("R4", "no pull-up on outputs", pad_pu, 8'h00);
  endtask

  task automatic t_mixed_pullup();
    logic [W-1:0] d, r, exp_pu;
    d = 8'h0F; r = 8'hF3;
    wr(2'd1, d);
    wr(2'd2, r);
    exp_pu = '0;
    for (int i = 0; i < W; i++) if (d[i] == 1'b0 && r[i] == 1'b1) exp_pu[i] = 1'b1;
    chk("R4", "pull-up mixed", pad_pu, exp_pu);
    chk("R3", "pad_out mixed", pad_out, 8'hF3);
    chk("R2", "pad_oe mixed", pad_oe, 8'h0F);
  endtask

  task automatic t_sync(input logic [W-1:0] dirv, input logic [W-1:0] newv);
    logic [W-1:0] v, oldv;
    wr(2'd1, dirv);
    oldv = pad_in;
    @(negedge clk);
    pad_in = newv;
    @(negedge clk);
    rd(2'd0, v); chk("R5", "level after one edge", v, oldv);
    @(negedge clk);
    rd(2'd0, v); chk("R5", "level after two edges", v, newv);
  endtask

  task automatic t_level_write_ignored();
    logic [W-1:0] v;
    wr(2'd1, 8'h33);
    wr(2'd2, 8'h44);
    wr(2'd0, 8'hFF);
    rd(2'd1, v); chk("R6", "dir after level write", v, 8'h33);
    rd(2'd2, v); chk("R6", "drive after level write", v, 8'h44);
    rd(2'd0, v); chk("R6", "level still pad", v, pad_in);
    chk("R6", "pad_out after level write", pad_out, 8'h44);
  endtask

  task automatic t_spare();
    logic [W-1:0] v;
    rd(2'd3, v); chk("R8", "spare reads zero", v, 8'h00);
    wr(2'd3, 8'hFF);
    rd(2'd3, v); chk("R8", "spare still zero", v, 8'h00);
    rd(2'd1, v); chk("R8", "dir after spare write", v, 8'h33);
    rd(2'd2, v); chk("R8", "drive after spare write", v, 8'h44);
  endtask

  task automatic t_override();
    logic [W-1:0] exp_out;
    wr(2'd1, 8'h0F);
    wr(2'd2, 8'h55);
    @(negedge clk);
    alt_sel = 8'h3C; alt_val = 8'hA0;
    #1;
    for (int i = 0; i < W; i++) exp_out[i] = alt_sel[i] ? alt_val[i] : 8'h55 >> i & 1'b1;
    chk("R7", "override value", pad_out, exp_out);
    chk("R7", "override keeps oe", pad_oe, 8'h0F);
    alt_sel = '0;
    #1;
    chk("R7", "override released", pad_out, 8'h55);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_dir_and_idle();
    t_drive_outputs();
    t_mixed_pullup();
    t_sync(8'h00, 8'h5A);
    t_sync(8'hFF, 8'hC3);
    t_level_write_ignored();
    t_spare();
    t_override();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog run hung actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule